// File: doc/BRIEF.md
# Peekable Streaming Queue with Spill Backlog

This block is a bounded first-in first-out queue that sits between a stream producer and a stream consumer. Besides the usual push (append at the tail) and pop (take from the head), it answers a peek request that returns the entry at any offset from the head without removing anything. Storage is split into a small primary ring, which always holds the oldest entries, and a backlog ring that only takes entries once the primary ring is full. When the head is popped, the oldest backlog entry moves into the primary ring in the same cycle. Seen from its ports, the split cannot be observed: the queue behaves exactly like one FIFO whose depth is the sum of the two rings.

Each operation is a request followed by a separate response. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Exactly one cycle later a one-cycle response pulse carries an error flag and, for pop and peek, the data. Only one request is outstanding at a time, so `req_ready` is low while a response is being presented.

Top module: `sq_top`

## Requirements
- R1: Entries leave through pop in exactly the order they were pushed, including entries that passed through the backlog. The pop response carries the head entry.
- R2: A peek with offset k (0 = head) below the occupancy returns the k-th oldest entry, with no error. It leaves the occupancy and the later pop order unchanged.
- R3: Total capacity is PRI_DEPTH+BKL_DEPTH. `full` is high exactly when that many entries are stored, and `empty` is high exactly when none are stored.
- R4: A push while full, or a pop while empty, gets a response with `rsp_err`=1 and `rsp_data`=0. The occupancy and the stored contents stay unchanged.
- R5: A peek whose offset is greater than or equal to the occupancy gets `rsp_err`=1 and `rsp_data`=0. Nothing changes.
- R6: `occupancy` equals the number of stored entries in every cycle. A successful push raises it by one, a successful pop lowers it by one, and nothing else changes it.
- R7: A request is accepted on an edge where `req_valid` and `req_ready` are both high. `rsp_valid` is high for exactly the one cycle after acceptance, and `req_ready` is low during that cycle.
- R8: A synchronous active-high `rst` empties the queue (`occupancy`=0, `empty`=1, `full`=0), clears `rsp_valid` and leaves `req_ready` high.
- R9: `req_op` encoding: 0 = push, 1 = pop, 2 = peek, 3 = reserved. A reserved request is answered with `rsp_err`=1 and `rsp_data`=0 and has no effect.
- R10: A push response that succeeds has `rsp_err`=0 and `rsp_data`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Queue can accept a request this cycle |
| req_op | input | 2 | Operation code (0 push, 1 pop, 2 peek, 3 reserved) |
| req_data | input | W | Entry to push |
| req_idx | input | CW | Peek offset from the head |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Request refused |
| rsp_data | output | W | Popped or peeked entry, zero otherwise |
| occupancy | output | CW | Number of stored entries across both rings |
| full | output | 1 | Occupancy equals total capacity |
| empty | output | 1 | Occupancy is zero |

## Verification
The bench fills the queue past the primary ring's depth, so the backlog is in use, and then drains it completely. A refill that moved the wrong backlog entry, or moved none, would show up as popped data out of order. It peeks at every offset, in particular offsets that straddle the boundary between the two rings and offsets equal to the occupancy. A design that indexed the backlog wrongly would return another entry, and one that did not bound the offset would return stale data without an error. It pushes while full, pops while empty and issues the reserved code. A design that let such a request through would change the occupancy or corrupt the order seen by later pops. Random traffic that swings between full and empty, plus a reset in the middle of the run, covers the counter and flag logic at both extremes.

// File: rtl/sq_pkg.sv
package sq_pkg;
    typedef enum logic [1:0] {
        OP_PUSH = 2'd0,
        OP_POP  = 2'd1,
        OP_PEEK = 2'd2,
        OP_RSVD = 2'd3
    } sq_op_e;
endpackage

// File: rtl/sq_ring.sv
// Circular store with simultaneous push/pop and a random-offset read port.
module sq_ring #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic [W-1:0]  wdata_i,
    input  logic          pop_i,
    input  logic [IW-1:0] rd_off_i,
    output logic [W-1:0]  head_o,
    output logic [W-1:0]  rd_o,
    output logic [CW-1:0] cnt_o
);
    typedef struct packed {
        logic [IW-1:0] rd_ptr;
        logic [IW-1:0] wr_ptr;
        logic [CW-1:0] cnt;
    } ring_st_t;

    ring_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic [IW:0]  off_sum;
    logic [IW-1:0] rd_idx;

    function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push_i) st_d.wr_ptr = bump(st_q.wr_ptr);
        if (pop_i)  st_d.rd_ptr = bump(st_q.rd_ptr);
        unique case ({push_i, pop_i})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        off_sum = {1'b0, st_q.rd_ptr} + {1'b0, rd_off_i};
        if (off_sum >= (IW+1)'(DEPTH))
            off_sum = off_sum - (IW+1)'(DEPTH);
        rd_idx = off_sum[IW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_i) mem[st_q.wr_ptr] <= wdata_i;
    end

    assign head_o = mem[st_q.rd_ptr];
    assign rd_o   = mem[rd_idx];
    assign cnt_o  = st_q.cnt;
endmodule

// File: rtl/sq_top.sv
// Peekable FIFO: primary ring holds the oldest entries, backlog ring absorbs spill.
module sq_top #(
    parameter int W         = 8,
    parameter int PRI_DEPTH = 4,
    parameter int BKL_DEPTH = 4,
    localparam int TOT      = PRI_DEPTH + BKL_DEPTH,
    localparam int CW       = $clog2(TOT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [W-1:0]  req_data,
    input  logic [CW-1:0] req_idx,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [W-1:0]  rsp_data,
    output logic [CW-1:0] occupancy,
    output logic          full,
    output logic          empty
);
    import sq_pkg::*;

    localparam int PIW = (PRI_DEPTH > 1) ? $clog2(PRI_DEPTH) : 1;
    localparam int BIW = (BKL_DEPTH > 1) ? $clog2(BKL_DEPTH) : 1;
    localparam int PCW = $clog2(PRI_DEPTH + 1);
    localparam int BCW = $clog2(BKL_DEPTH + 1);

    typedef struct packed {
        logic         rsp_valid;
        logic         rsp_err;
        logic [W-1:0] rsp_data;
    } top_st_t;

    top_st_t st_d, st_q;

    logic           p_push, p_pop, b_push, b_pop;
    logic [W-1:0]   p_wdata;
    logic [PIW-1:0] p_off;
    logic [BIW-1:0] b_off;
    logic [W-1:0]   p_head, p_rd, b_head, b_rd;
    logic [PCW-1:0] p_cnt;
    logic [BCW-1:0] b_cnt;
    logic [CW-1:0]  total;
    logic           accept, p_full;
    sq_op_e         op;

    sq_ring #(.W(W), .DEPTH(PRI_DEPTH)) pri_i (
        .clk(clk), .rst(rst),
        .push_i(p_push), .wdata_i(p_wdata), .pop_i(p_pop),
        .rd_off_i(p_off), .head_o(p_head), .rd_o(p_rd), .cnt_o(p_cnt)
    );

    sq_ring #(.W(W), .DEPTH(BKL_DEPTH)) bkl_i (
        .clk(clk), .rst(rst),
        .push_i(b_push), .wdata_i(req_data), .pop_i(b_pop),
        .rd_off_i(b_off), .head_o(b_head), .rd_o(b_rd), .cnt_o(b_cnt)
    );

    always_comb begin
        total   = CW'(p_cnt) + CW'(b_cnt);
        p_full  = (p_cnt == PCW'(PRI_DEPTH));
        accept  = req_valid && !st_q.rsp_valid;
        op      = sq_op_e'(req_op);
        p_push  = 1'b0;
        p_pop   = 1'b0;
        b_push  = 1'b0;
        b_pop   = 1'b0;
        p_wdata = req_data;
        p_off   = PIW'(req_idx);
        b_off   = BIW'(req_idx - CW'(p_cnt));

        st_d           = st_q;
        st_d.rsp_valid = accept;
        if (accept) begin
            st_d.rsp_err  = 1'b0;
            st_d.rsp_data = '0;
            unique case (op)
                OP_PUSH: begin
                    if (total == CW'(TOT)) st_d.rsp_err = 1'b1;
                    else if (p_full)       b_push = 1'b1;
                    else                   p_push = 1'b1;
                end
                OP_POP: begin
                    if (total == '0) begin
                        st_d.rsp_err = 1'b1;
                    end else begin
                        p_pop         = 1'b1;
                        st_d.rsp_data = p_head;
                        if (b_cnt != '0) begin
                            // refill: oldest backlog entry joins primary tail
                            b_pop   = 1'b1;
                            p_push  = 1'b1;
                            p_wdata = b_head;
                        end
                    end
                end
                OP_PEEK: begin
                    if (req_idx >= total)             st_d.rsp_err  = 1'b1;
                    else if (req_idx < CW'(p_cnt))    st_d.rsp_data = p_rd;
                    else                              st_d.rsp_data = b_rd;
                end
                default: st_d.rsp_err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign req_ready = !st_q.rsp_valid;
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_err   = st_q.rsp_err;
    assign rsp_data  = st_q.rsp_data;
    assign occupancy = total;
    assign full      = (total == CW'(TOT));
    assign empty     = (total == '0);
endmodule

// File: rtl/sq_top_chk.sv
module sq_top_chk #(
    parameter int PRI_DEPTH = 4,
    parameter int BKL_DEPTH = 4,
    localparam int TOT      = PRI_DEPTH + BKL_DEPTH,
    localparam int CW       = $clog2(TOT + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic [1:0]    req_op,
    input logic          rsp_valid,
    input logic          rsp_err,
    input logic [CW-1:0] occupancy,
    input logic          full,
    input logic          empty
);
    // R3
    full_flag_chk: assert property (@(posedge clk) disable iff (rst)
        full == (occupancy == CW'(TOT)));
    // R3
    empty_flag_chk: assert property (@(posedge clk) disable iff (rst)
        empty == (occupancy == '0));
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        occupancy <= CW'(TOT));
    // R7
    rsp_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (rsp_valid && !req_ready));
    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    // R6
    occ_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> $stable(occupancy));
    // R4
    refused_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> $stable(occupancy));
    // R6
    pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err && $past(req_op) == 2'd1)
            |-> occupancy == $past(occupancy) - CW'(1));
    // R6
    push_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err && $past(req_op) == 2'd0)
            |-> occupancy == $past(occupancy) + CW'(1));
endmodule

bind sq_top sq_top_chk #(.PRI_DEPTH(PRI_DEPTH), .BKL_DEPTH(BKL_DEPTH)) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .occupancy(occupancy), .full(full), .empty(empty)
);

// File: tb/sq_top_tb_top.sv
module sq_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 8;
    localparam int N   = 4;
    localparam int P   = 4;
    localparam int TOT = N + P;
    localparam int CW  = $clog2(TOT + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [W-1:0]  req_data = '0;
    logic [CW-1:0] req_idx = '0;
    logic          rsp_valid, rsp_err, full, empty;
    logic [W-1:0]  rsp_data;
    logic [CW-1:0] occupancy;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] model [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sq_top #(.W(W), .PRI_DEPTH(N), .BKL_DEPTH(P)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_data(req_data), .req_idx(req_idx),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .occupancy(occupancy), .full(full), .empty(empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_err(input logic [1:0] op, input int idx, input int sz);
        case (op)
            2'd0:    return sz == TOT;
            2'd1:    return sz == 0;
            2'd2:    return idx >= sz;
            default: return 1'b1;
        endcase
    endfunction

    function automatic int exp_data(input logic [1:0] op, input int idx, input int sz);
        if (exp_err(op, idx, sz)) return 0;
        if (op == 2'd1) return int'(model[0]);
        if (op == 2'd2) return int'(model[idx]);
        return 0;
    endfunction

    // called at a negedge
    task automatic do_op(input logic [1:0] op, input logic [W-1:0] d, input int idx);
        int  sz = model.size();
        bit  e  = exp_err(op, idx, sz);
        int  ed = exp_data(op, idx, sz);
        string rq;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_data = d; req_idx = CW'(idx);
        @(negedge clk);
        req_valid = 1'b0;
        if (!e) begin
            if (op == 2'd0) model.push_back(d);
            else if (op == 2'd1) void'(model.pop_front());
        end
        case (op)
            2'd0: rq = e ? "R4" : "R10";
            2'd1: rq = e ? "R4" : "R1";
            2'd2: rq = e ? "R5" : "R2";
            default: rq = "R9";
        endcase
        chk(rsp_valid == 1'b1, "R7 rsp_valid", int'(rsp_valid), 1);
        chk(req_ready == 1'b0, "R7 req_ready", int'(req_ready), 0);
        chk(rsp_err == e, {rq, " err"}, int'(rsp_err), int'(e));
        chk(int'(rsp_data) == ed, {rq, " data"}, int'(rsp_data), ed);
        chk(int'(occupancy) == model.size(), "R6 occupancy", int'(occupancy), model.size());
        chk(full == (model.size() == TOT), "R3 full", int'(full), int'(model.size() == TOT));
        chk(empty == (model.size() == 0), "R3 empty", int'(empty), int'(model.size() == 0));
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R7 pulse", int'(rsp_valid), 0);
    endtask

    task automatic check_reset_state();
        chk(int'(occupancy) == 0, "R8 occupancy", int'(occupancy), 0);
        chk(empty == 1'b1, "R8 empty", int'(empty), 1);
        chk(full == 1'b0, "R8 full", int'(full), 0);
        chk(rsp_valid == 1'b0, "R8 rsp_valid", int'(rsp_valid), 0);
        chk(req_ready == 1'b1, "R8 req_ready", int'(req_ready), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_reset_state();

        // directed: empty refusals, reserved op
        do_op(2'd1, 8'h00, 0);           // R4 pop empty
        do_op(2'd2, 8'h00, 0);           // R5 peek empty
        do_op(2'd3, 8'h11, 0);           // R9 reserved
        // fill through the backlog to capacity (R1, R3)
        for (int i = 0; i < TOT; i++) do_op(2'd0, 8'(8'hA0 + i), 0);
        do_op(2'd0, 8'hFF, 0);           // R4 push full
        do_op(2'd3, 8'h22, 0);           // R9 reserved while full
        // peek every offset, including the ring boundary and out of range (R2, R5)
        for (int k = 0; k <= TOT + 1; k++) do_op(2'd2, 8'h00, k);
        // partial drain crosses the refill path, then peek again
        for (int i = 0; i < 3; i++) do_op(2'd1, 8'h00, 0);
        for (int k = 0; k < TOT; k++) do_op(2'd2, 8'h00, k);
        for (int i = 0; i < 3; i++) do_op(2'd0, 8'(8'hC0 + i), 0);
        for (int i = 0; i <= TOT; i++) do_op(2'd1, 8'h00, 0);

        // constrained random traffic in push-heavy and pop-heavy phases
        for (int ph = 0; ph < 20; ph++) begin
            for (int n = 0; n < 150; n++) begin
                int r = int'($urandom_range(99, 0));
                int pw = (ph % 2 == 0) ? 60 : 25;
                logic [1:0] op;
                if (r < pw) op = 2'd0;
                else if (r < 85) op = 2'd1;
                else if (r < 97) op = 2'd2;
                else op = 2'd3;
                do_op(op, 8'($urandom), int'($urandom_range(TOT + 2, 0)));
            end
        end

        // reset with data stored (R8)
        for (int i = 0; i < 5; i++) do_op(2'd0, 8'(8'h50 + i), 0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model.delete();
        check_reset_state();
        do_op(2'd1, 8'h00, 0);           // R8 nothing left after reset
        do_op(2'd0, 8'h77, 0);
        do_op(2'd2, 8'h00, 0);
        do_op(2'd1, 8'h00, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule